// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one capture channel of a general-purpose timer. It watches a single external timer input, moves it into the clock domain through a synchronizer, and cleans it with a digital filter whose length is set in software. It then picks the rising or falling edge and thins the accepted edges with an event divider. On every qualified event it stores the value of an external free-running counter in a capture register. It also sets a capture flag, sets an overcapture flag when the previous result was never collected, and drives an interrupt line and a DMA request.

Software reaches the channel through a small word-addressed register port. The port holds the configuration, the flags (write one to clear), a software capture trigger and the captured value. Reading the captured value also collects it: the capture flag drops on that read. The counter time base is outside the block and arrives on an input port.

Top module: `cap_channel`

## Requirements
- R12: After reset the configuration, both flags, the capture value, the interrupt and the DMA request are all zero.
- R1: A qualified edge is captured one clock after the filtered level changes. With SYNC_STAGES=2 and a filter length N, an input edge set up before clock edge k stores the counter value present at clock edge k+2+N in the capture register (address 3) and sets the capture flag (status bit 0, address 1).
- R2: A capture that occurs while the capture flag is already set also sets the overcapture flag (status bit 1).
- R3: Writing 1 to status bit 0 clears the capture flag, and so does reading address 3. The read returns the captured value.
- R4: The overcapture flag is cleared only by writing 1 to status bit 1. Reading address 3 and writing 1 to status bit 0 leave it set.
- R5: Configuration bit 1 (address 0) selects the active edge: 0 captures on rising edges only, 1 on falling edges only.
- R6: Configuration bits [3:2] set the event divider: codes 0, 1, 2 and 3 capture on every 1st, 2nd, 4th and 8th qualified edge.
- R7: Captures happen only while configuration bit 0 (enable) is set. While it is clear, the divider count returns to zero.
- R8: Configuration bit 8 gates a level interrupt equal to the capture flag. Configuration bit 9 gates a DMA request that pulses high for one cycle after each capture.
- R9: Writing address 2 with bit 0 set forces a capture while enabled. It stores the counter value at that write's clock edge, and the event divider does not apply to it.
- R10: Configuration bits [7:4] give a filter length N (0 is treated as 1). The filtered level follows the input only after N consecutive samples differ from it, so shorter pulses are ignored.
- R11: If a capture happens in the same cycle as a capture-register read or a status write that clears the flag, the capture wins: the flag stays set and the new value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tIn | input | 1 | Raw external timer input |
| counterIn | input | CNT_W | Free-running counter value |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address (0 config, 1 status, 2 event, 3 capture) |
| regWrData | input | 10 | Register write data |
| regRdData | output | CNT_W | Register read data (combinational) |
| irqOut | output | 1 | Capture interrupt |
| dmaReq | output | 1 | DMA request pulse |

## Verification
Two things can land on the same clock edge here: a hardware capture, and a software access that drops the capture flag, either a read of the capture register or a write-one-to-clear. The bench knows the exact latency from input to capture. It times an input edge so that the capture lands on the very edge where the read is presented, then does the same again with the clearing write. It then requires the flag to remain set and the register to hold the new counter value.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int FILT_W   = 4;
  localparam int CFG_BITS = 10;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_EVT  = 2'd2;
  localparam logic [1:0] ADDR_CAP  = 2'd3;

  // packed MSB first: bit9 dmaEn ... bit0 enable
  typedef struct packed {
    logic              dmaEn;
    logic              irqEn;
    logic [FILT_W-1:0] filtLen;
    logic [1:0]        presc;
    logic              fallEdge;
    logic              enable;
  } capCfg_t;

  typedef struct packed {
    logic doCapture;
    logic readCap;
    logic clrFlag;
    logic clrOver;
  } capStrobe_t;
endpackage

// File: rtl/cap_channel_ctrl.sv
module cap_channel_ctrl
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tIn,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [CFG_BITS-1:0] regWrData,
  output capCfg_t             cfg,
  output capStrobe_t          strobe
);
  localparam int PCNT_W = 3;

  // synchronizer chain
  logic [SYNC_STAGES-1:0] syncQ;
  logic synced;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], tIn};
  end
  assign synced = syncQ[SYNC_STAGES-1];

  // configuration register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfg <= '0;
    else if (regWrEn && regAddr == ADDR_CFG) cfg <= capCfg_t'(regWrData);
  end

  // sampling filter
  logic [FILT_W-1:0] filtCnt;
  logic [FILT_W:0]   filtNeed, filtNext;
  logic filtLevel, prevLevel;
  assign filtNeed = (cfg.filtLen == '0) ? (FILT_W+1)'(1) : {1'b0, cfg.filtLen};
  assign filtNext = {1'b0, filtCnt} + (FILT_W+1)'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtCnt   <= '0;
      filtLevel <= 1'b0;
      prevLevel <= 1'b0;
    end else begin
      prevLevel <= filtLevel;
      if (synced == filtLevel) begin
        filtCnt <= '0;
      end else if (filtNext >= filtNeed) begin
        filtLevel <= synced;
        filtCnt   <= '0;
      end else begin
        filtCnt <= filtNext[FILT_W-1:0];
      end
    end
  end

  // edge select and event divider
  logic rawEdge, qualEdge, prescHit;
  logic [PCNT_W-1:0] pCnt, divLast;
  assign rawEdge  = cfg.fallEdge ? (prevLevel & ~filtLevel) : (filtLevel & ~prevLevel);
  assign qualEdge = rawEdge & cfg.enable;

  always_comb begin
    case (cfg.presc)
      2'd0:    divLast = PCNT_W'(0);
      2'd1:    divLast = PCNT_W'(1);
      2'd2:    divLast = PCNT_W'(3);
      default: divLast = PCNT_W'(7);
    endcase
  end
  assign prescHit = qualEdge && (pCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pCnt <= '0;
    else if (!cfg.enable)   pCnt <= '0;
    else if (prescHit)      pCnt <= '0;
    else if (qualEdge)      pCnt <= pCnt + PCNT_W'(1);
  end

  // strobes toward the datapath
  logic swEvent;
  assign swEvent          = regWrEn && regAddr == ADDR_EVT && regWrData[0];
  assign strobe.doCapture = (prescHit | swEvent) & cfg.enable;
  assign strobe.readCap   = regRdEn && regAddr == ADDR_CAP;
  assign strobe.clrFlag   = regWrEn && regAddr == ADDR_STAT && regWrData[0];
  assign strobe.clrOver   = regWrEn && regAddr == ADDR_STAT && regWrData[1];

  // R7: nothing is captured while disabled
  a_r7_no_capture_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> !strobe.doCapture);
  // R7: divider count returns to zero while disabled
  a_r7_divider_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> pCnt == '0);
  // R10: the filtered level only moves toward the synchronized sample
  a_r10_filter_follows: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtLevel) |-> filtLevel == $past(synced));
endmodule

// File: rtl/cap_channel_data.sv
module cap_channel_data
  import cap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] counterIn,
  input  capStrobe_t       strobe,
  input  logic             irqEn,
  input  logic             dmaEn,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             overFlag,
  output logic             irqOut,
  output logic             dmaReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capValue <= '0;
      capFlag  <= 1'b0;
      overFlag <= 1'b0;
      dmaReq   <= 1'b0;
    end else begin
      dmaReq <= strobe.doCapture & dmaEn;
      if (strobe.doCapture) capValue <= counterIn;
      if (strobe.doCapture)                        capFlag <= 1'b1;
      else if (strobe.clrFlag || strobe.readCap)   capFlag <= 1'b0;
      if (strobe.doCapture && capFlag)             overFlag <= 1'b1;
      else if (strobe.clrOver)                     overFlag <= 1'b0;
    end
  end

  assign irqOut = capFlag & irqEn;

  // R1: a capture stores the counter and raises the flag
  a_r1_capture_loads: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCapture |=> (capValue == $past(counterIn)) && capFlag);
  // R2: capture on a pending flag marks overcapture
  a_r2_overcapture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCapture && capFlag |=> overFlag);
  // R4: overcapture holds until its own clear
  a_r4_over_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overFlag && !strobe.clrOver |=> overFlag);
  // R11: capture beats a same-cycle read
  a_r11_capture_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCapture && (strobe.readCap || strobe.clrFlag) |=> capFlag);
  // R8: a DMA pulse always follows a capture
  a_r8_dma_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> $past(strobe.doCapture));
endmodule

// File: rtl/cap_channel.sv
module cap_channel
  import cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tIn,
  input  logic [CNT_W-1:0]    counterIn,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [CFG_BITS-1:0] regWrData,
  output logic [CNT_W-1:0]    regRdData,
  output logic                irqOut,
  output logic                dmaReq
);
  capCfg_t    cfg;
  capStrobe_t strobe;
  logic [CNT_W-1:0] capValue;
  logic capFlag, overFlag;

  cap_channel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tIn(tIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .cfg(cfg), .strobe(strobe)
  );

  cap_channel_data #(.CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .counterIn(counterIn), .strobe(strobe),
    .irqEn(cfg.irqEn), .dmaEn(cfg.dmaEn),
    .capValue(capValue), .capFlag(capFlag), .overFlag(overFlag),
    .irqOut(irqOut), .dmaReq(dmaReq)
  );

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdData = CNT_W'(cfg);
      ADDR_STAT: regRdData = CNT_W'({overFlag, capFlag});
      ADDR_CAP:  regRdData = capValue;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: tb/cap_channel_test.sv
module cap_channel_test;
  localparam int CNT_W = 16;
  logic clk = 1'b0, rstN = 1'b0, tIn = 1'b0;
  logic [CNT_W-1:0] counterIn = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [9:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic irqOut, dmaReq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always @(negedge clk) counterIn <= counterIn + 16'd1;

  cap_channel uut (.clk(clk), .rstN(rstN), .tIn(tIn), .counterIn(counterIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut), .dmaReq(dmaReq));

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic logic [9:0] cfgWord(bit en, bit fall, int presc, int filt, bit irq, bit dma);
    return {dma, irq, 4'(filt), 2'(presc), fall, en};
  endfunction

  task automatic regWrite(logic [1:0] a, logic [9:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(logic [1:0] a, output int v);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; #1 v = int'(regRdData);
    @(negedge clk); regRdEn = 1'b0;
  endtask

  // peek without side effects (status reads have none)
  task automatic status(output int v); regRead(2'd1, v); endtask

  // drive a level, return the counter seen in that half cycle
  task automatic drive(logic v, output int c0);
    @(negedge clk); tIn = v; #1 c0 = int'(counterIn);
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic clearAll(); regWrite(2'd1, 10'b11); endtask

  task automatic pulse(); int c; drive(1'b1, c); idle(6); drive(1'b0, c); idle(6); endtask

  task automatic t_reset();
    int v;
    regRead(2'd0, v); check("R12 cfg", v, 0);
    status(v);        check("R12 status", v, 0);
    regRead(2'd3, v); check("R12 capture", v, 0);
    check("R12 irq", irqOut, 0);
    check("R12 dma", dmaReq, 0);
  endtask

  task automatic t_basic();
    int c0, v;
    regWrite(2'd0, cfgWord(1, 0, 0, 0, 1, 0));
    drive(1'b1, c0); idle(3);
    status(v);        check("R1 flag set", v, 1);
    check("R8 irq high", irqOut, 1);
    regRead(2'd3, v); check("R1 value", v, c0 + 3);
    status(v);        check("R3 read clears flag", v, 0);
    check("R8 irq low", irqOut, 0);
    drive(1'b0, c0); idle(6);
  endtask

  task automatic t_over();
    int c0, v;
    pulse(); pulse();
    status(v); check("R2 overcapture", v, 3);
    regRead(2'd3, v); status(v); check("R4 read keeps over", v, 2);
    regWrite(2'd1, 10'b01); status(v); check("R4 flag clear keeps over", v, 2);
    regWrite(2'd1, 10'b10); status(v); check("R4 over cleared", v, 0);
    pulse(); regWrite(2'd1, 10'b01); status(v); check("R3 w1c clears flag", v, 0);
  endtask

  task automatic t_polarity();
    int c0, v;
    regWrite(2'd0, cfgWord(1, 1, 0, 0, 0, 0));
    drive(1'b1, c0); idle(6);
    status(v); check("R5 rising ignored", v, 0);
    drive(1'b0, c0); idle(3);
    regRead(2'd3, v); check("R5 falling value", v, c0 + 3);
    clearAll();
  endtask

  task automatic t_presc();
    int v;
    for (int p = 1; p < 4; p++) begin
      regWrite(2'd0, cfgWord(0, 0, p, 0, 0, 0));
      regWrite(2'd0, cfgWord(1, 0, p, 0, 0, 0));
      clearAll();
      for (int i = 0; i < (1 << p) - 1; i++) pulse();
      status(v); check($sformatf("R6 code %0d before", p), v, 0);
      pulse();
      status(v); check($sformatf("R6 code %0d hit", p), v, 1);
      clearAll();
    end
  endtask

  task automatic t_enable();
    int v;
    regWrite(2'd0, cfgWord(0, 0, 0, 0, 1, 1));
    pulse(); regWrite(2'd2, 10'b1);
    status(v); check("R7 disabled no capture", v, 0);
    check("R7 disabled no dma", dmaReq, 0);
    regWrite(2'd0, cfgWord(1, 0, 2, 0, 0, 0));
    pulse(); pulse();
    regWrite(2'd0, cfgWord(0, 0, 2, 0, 0, 0));
    regWrite(2'd0, cfgWord(1, 0, 2, 0, 0, 0));
    pulse(); pulse(); pulse();
    status(v); check("R7 divider restarted", v, 0);
    pulse();
    status(v); check("R7 fourth after restart", v, 1);
    clearAll();
  endtask

  task automatic t_swEvent();
    int c, v;
    regWrite(2'd0, cfgWord(1, 0, 3, 0, 0, 1));
    @(negedge clk); regWrEn = 1'b1; regAddr = 2'd2; regWrData = 10'b1; #1 c = int'(counterIn);
    @(negedge clk); regWrEn = 1'b0; regWrData = '0;
    check("R8 dma pulse", dmaReq, 1);
    @(negedge clk); check("R8 dma one cycle", dmaReq, 0);
    regRead(2'd3, v); check("R9 software capture value", v, c);
    clearAll();
  endtask

  task automatic t_filter();
    int c0, v;
    regWrite(2'd0, cfgWord(1, 0, 0, 4, 0, 0));
    drive(1'b1, c0); idle(2); drive(1'b0, c0); idle(8);
    status(v); check("R10 glitch ignored", v, 0);
    drive(1'b1, c0); idle(6);
    regRead(2'd3, v); check("R10 filtered value", v, c0 + 6);
    drive(1'b0, c0); idle(8);
    clearAll();
  endtask

  task automatic t_collide();
    int c0, v;
    regWrite(2'd0, cfgWord(1, 0, 0, 0, 0, 0));
    drive(1'b1, c0); idle(2);
    regRead(2'd3, v);
    status(v); check("R11 read vs capture flag", v, 1);
    regRead(2'd3, v); check("R11 read vs capture value", v, c0 + 3);
    drive(1'b0, c0); idle(6);
    drive(1'b1, c0); idle(2);
    regWrite(2'd1, 10'b01);
    status(v); check("R11 clear vs capture flag", v, 1);
    clearAll(); drive(1'b0, c0); idle(6);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); rstN = 1'b1; idle(2);
    t_reset(); t_basic(); t_over(); t_polarity(); t_presc();
    t_enable(); t_swEvent(); t_filter(); t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule